// File: doc/BRIEF.md
# Time-of-Day Calendar Counter

This block holds a wall-clock time and calendar: seconds, minutes, hours, weekday, date, month and a two-digit year. A one-cycle pulse on `tick_1hz` starts an update window. The update-in-progress status goes high at once. A fixed number of timebase cycles later, the whole chain advances by one second. The status stays high for a further hold time, and when it drops an update-ended flag is raised. The flag can be routed to an interrupt output.

A host reaches every field through a byte-wide indexed register port. A control register picks how the fields are shown to the host. Values are BCD or plain binary, and hours are kept in 24-hour form or in 12-hour form with a PM marker. Internally each field is kept in binary, so a mode change only alters how a field is presented. A freeze bit in the control register lets the host load a new time without it moving underneath.

Top module: `tod_clock`

## Requirements
- R1: After reset, indices 0, 2, 4, 6, 7, 8, 9 read 0x00, 0x00, 0x12, 0x01, 0x01, 0x01, 0x00. At reset the mode is BCD, 12-hour, midnight, weekday 1, 1 January, year 0. Indices 10, 11 and 12 read 0x00, and `uip` and `irq` are low.
- R2: A tick taken while idle raises `uip` one cycle later. `uip` then stays high for LEAD+HOLD cycles, which default to 8+65 with a 32768 Hz timebase. The time fields change exactly LEAD cycles after `uip` rises. Bit 7 of index 10 mirrors `uip`. The fields hold their value outside an advance or a host write.
- R3: Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0.
- R4: The weekday (index 6) steps 1..7 and wraps 7→1 when the hour wraps at midnight.
- R5: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of 4, and 28 otherwise. All other months have 31 days. December rolls to January and increments the year. Year 99 rolls to 0.
- R6: Control bit 2 (index 11) clear means every field is read and written as BCD; set means plain binary. Changing the bit re-encodes the held value without altering it.
- R7: Control bit 1 set selects 24-hour hours. When it is clear, hours read as 12, 1, ..., 11 with bit 7 marking PM. 11 AM steps to 12 PM, 12 PM steps to 1 PM, and 11 PM steps to 12 AM.
- R8: While control bit 7 (freeze) is set, a tick is ignored: `uip` stays low, no field advances and no update-ended flag is raised.
- R9: When `uip` falls, bit 4 of index 12 is set. Bit 7 of index 12 and the `irq` output show that flag ANDed with control bit 4. A read of index 12 with `reg_rd` clears it.
- R10: Writes to index 10 are ignored. Bits 6..0 of index 10 read 0, and unused indices (1, 3, 5, 13..15) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| reg_idx | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_idx` |
| reg_rd | input | 1 | Read strobe; clears the flags when `reg_idx` is 12 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx`, combinational |
| uip | output | 1 | Update-in-progress window |
| irq | output | 1 | Update-ended interrupt |

## Verification
On every cycle, the assertions check the following:
- the window's shape: an advance is followed by a still-open window, and the end of the window closes it;
- a frozen clock neither opens a window nor moves any field;
- a field changes only on an advance or a host write;
- the update-ended flag rises only after a window and persists until it is read.

The carry chain, month lengths, leap years, the BCD, binary and 12-hour encodings, and the exact lead count are shown only by the bench's vectors and directed scenarios.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam logic [3:0] IDX_SEC  = 4'd0;
  localparam logic [3:0] IDX_MIN  = 4'd2;
  localparam logic [3:0] IDX_HOUR = 4'd4;
  localparam logic [3:0] IDX_WDAY = 4'd6;
  localparam logic [3:0] IDX_MDAY = 4'd7;
  localparam logic [3:0] IDX_MON  = 4'd8;
  localparam logic [3:0] IDX_YEAR = 4'd9;
  localparam logic [3:0] IDX_STAT = 4'd10;
  localparam logic [3:0] IDX_CTRL = 4'd11;
  localparam logic [3:0] IDX_FLAG = 4'd12;

  localparam int unsigned CTL_FRZ = 7;
  localparam int unsigned CTL_UIE = 4;
  localparam int unsigned CTL_BIN = 2;
  localparam int unsigned CTL_24H = 1;
  localparam logic [7:0]  CTL_MASK = 8'h96;

  localparam int unsigned NFIELD = 7;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    logic [7:0] s;
    s = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    return s[6:0];
  endfunction

  function automatic logic [7:0] encode(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] decode(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/tod_upd_seq.sv
module tod_upd_seq #(
  parameter int unsigned LEAD_CYC = 8,
  parameter int unsigned HOLD_CYC = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic freeze,
  output logic uip,
  output logic adv,
  output logic done
);
  localparam int unsigned MAXC = (LEAD_CYC > HOLD_CYC) ? LEAD_CYC : HOLD_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_HOLD} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seq_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    adv   = 1'b0;
    done  = 1'b0;
    case (st_q)
      S_IDLE: if (tick && !freeze) begin
        st_d  = S_LEAD;
        cnt_d = '0;
      end
      S_LEAD: if (cnt_q == LEAD_LAST) begin
        adv   = 1'b1;
        st_d  = S_HOLD;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      S_HOLD: if (cnt_q == HOLD_LAST) begin
        done  = 1'b1;
        st_d  = S_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign seq_en = (st_q != S_IDLE) || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign uip = (st_q != S_IDLE);

  // R8: a frozen clock never opens a window
  assert_freeze_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && freeze && !uip) |=> !uip);
  // R2: the window is still open after the advance
  assert_adv_then_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> uip);
  // R2: end of window closes it
  assert_done_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !uip);

endmodule

// File: rtl/tod_cal_core.sv
module tod_cal_core
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [NFIELD-1:0] wr_sel,
  input  logic [6:0]        wr_val,
  output tod_t              cur
);
  localparam tod_t TOD_RST = '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                               hour: 5'd0, min: 6'd0, sec: 6'd0};

  tod_t       nxt;
  logic [4:0] mlen;
  logic       c_sec, c_min, c_hr, c_day, c_mon;
  logic       cal_en;

  always_comb begin
    nxt   = cur;
    mlen  = month_days(cur.mon, cur.year);
    c_sec = cur.sec >= 6'd59;
    c_min = c_sec && (cur.min >= 6'd59);
    c_hr  = c_min && (cur.hour >= 5'd23);
    c_day = c_hr && (cur.mday >= mlen);
    c_mon = c_day && (cur.mon >= 4'd12);
    if (adv) begin
      nxt.sec = c_sec ? 6'd0 : cur.sec + 6'd1;
      if (c_sec) nxt.min  = c_min ? 6'd0 : cur.min + 6'd1;
      if (c_min) nxt.hour = c_hr ? 5'd0 : cur.hour + 5'd1;
      if (c_hr) begin
        nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
        nxt.mday = c_day ? 5'd1 : cur.mday + 5'd1;
      end
      if (c_day) nxt.mon  = c_mon ? 4'd1 : cur.mon + 4'd1;
      if (c_mon) nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
    end
    if (wr_sel[0]) nxt.sec  = wr_val[5:0];
    if (wr_sel[1]) nxt.min  = wr_val[5:0];
    if (wr_sel[2]) nxt.hour = wr_val[4:0];
    if (wr_sel[3]) nxt.wday = wr_val[2:0];
    if (wr_sel[4]) nxt.mday = wr_val[4:0];
    if (wr_sel[5]) nxt.mon  = wr_val[3:0];
    if (wr_sel[6]) nxt.year = wr_val;
  end

  assign cal_en = adv || (|wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= TOD_RST;
    else if (cal_en) cur <= nxt;
  end

  // R2: fields move only on an advance or a host write
  assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && (wr_sel == '0)) |=> $stable(cur));

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned TB_HZ    = 32768,
  parameter int unsigned LEAD_US  = 244,
  parameter int unsigned HOLD_US  = 1984
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic [3:0] reg_idx,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       uip,
  output logic       irq
);
  localparam int unsigned LEAD_RAW = (TB_HZ * LEAD_US + 500000) / 1000000;
  localparam int unsigned HOLD_RAW = (TB_HZ * HOLD_US + 500000) / 1000000;
  localparam int unsigned LEAD_CYC = (LEAD_RAW < 1) ? 1 : LEAD_RAW;
  localparam int unsigned HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [7:0]        ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic              uf_q, uf_d, uf_clr;
  logic              adv, done, bin, h24;
  logic [NFIELD-1:0] wr_sel;
  logic [6:0]        wval, w12, w12b, hour_wr;
  logic              h_pm;
  logic [4:0]        h_mod, h12;
  logic [7:0]        hour_rd;
  tod_t              cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign bin = ctrl_q[CTL_BIN];
  assign h24 = ctrl_q[CTL_24H];

  tod_upd_seq #(.LEAD_CYC(LEAD_CYC), .HOLD_CYC(HOLD_CYC)) seq_i (
    .clk(clk), .rst_n(rst_ni), .tick(tick_1hz), .freeze(ctrl_q[CTL_FRZ]),
    .uip(uip), .adv(adv), .done(done)
  );

  always_comb begin
    wval    = decode(reg_wdata, bin);
    w12     = decode({1'b0, reg_wdata[6:0]}, bin);
    w12b    = (w12 == 7'd12) ? 7'd0 : w12;
    hour_wr = h24 ? wval : w12b + (reg_wdata[7] ? 7'd12 : 7'd0);
    wr_sel  = '0;
    if (reg_wr) begin
      case (reg_idx)
        IDX_SEC:  wr_sel[0] = 1'b1;
        IDX_MIN:  wr_sel[1] = 1'b1;
        IDX_HOUR: wr_sel[2] = 1'b1;
        IDX_WDAY: wr_sel[3] = 1'b1;
        IDX_MDAY: wr_sel[4] = 1'b1;
        IDX_MON:  wr_sel[5] = 1'b1;
        IDX_YEAR: wr_sel[6] = 1'b1;
        default:  wr_sel    = '0;
      endcase
    end
  end

  tod_cal_core cal_i (
    .clk(clk), .rst_n(rst_ni), .adv(adv), .wr_sel(wr_sel),
    .wr_val((reg_idx == IDX_HOUR) ? hour_wr : wval), .cur(cur)
  );

  assign ctrl_en = reg_wr && (reg_idx == IDX_CTRL);
  assign ctrl_d  = reg_wdata & CTL_MASK;
  assign uf_clr  = reg_rd && (reg_idx == IDX_FLAG);
  assign uf_d    = done ? 1'b1 : (uf_clr ? 1'b0 : uf_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
      uf_q   <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (done || uf_clr) uf_q <= uf_d;
    end
  end

  assign irq = uf_q && ctrl_q[CTL_UIE];

  always_comb begin
    h_pm    = cur.hour >= 5'd12;
    h_mod   = h_pm ? cur.hour - 5'd12 : cur.hour;
    h12     = (h_mod == 5'd0) ? 5'd12 : h_mod;
    hour_rd = h24 ? encode({2'b0, cur.hour}, bin)
                  : ({h_pm, 7'b0} | encode({2'b0, h12}, bin));
    case (reg_idx)
      IDX_SEC:  reg_rdata = encode({1'b0, cur.sec}, bin);
      IDX_MIN:  reg_rdata = encode({1'b0, cur.min}, bin);
      IDX_HOUR: reg_rdata = hour_rd;
      IDX_WDAY: reg_rdata = encode({4'b0, cur.wday}, bin);
      IDX_MDAY: reg_rdata = encode({2'b0, cur.mday}, bin);
      IDX_MON:  reg_rdata = encode({3'b0, cur.mon}, bin);
      IDX_YEAR: reg_rdata = encode(cur.year, bin);
      IDX_STAT: reg_rdata = {uip, 7'b0};
      IDX_CTRL: reg_rdata = ctrl_q;
      IDX_FLAG: reg_rdata = {irq, 2'b00, uf_q, 4'b0000};
      default:  reg_rdata = 8'h00;
    endcase
  end

  // R9: the update-ended flag only rises at the close of a window
  assert_flag_after_window_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(uf_q) |-> $past(uip));
  // R9: the flag persists until a read of index 12
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (uf_q && !uf_clr) |=> uf_q);
  // R8: frozen and idle, with no host write, the time does not move
  assert_frozen_time_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[CTL_FRZ] && !uip && !reg_wr) |=> $stable(cur));

endmodule

// File: tb/tod_clock_tb_top.sv
`timescale 1ns/1ps
module tod_clock_tb_top;

  localparam int LEAD = 8;
  localparam int HOLD = 65;

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  ctrl;
    logic [55:0] din;   // sec, min, hour, wday, mday, mon, year
    logic [55:0] dexp;
  } vec_t;

  localparam logic [3:0] FIDX [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  localparam vec_t VECS [13] = '{
    '{8'd3, 8'h02, {8'h56,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24}, {8'h57,8'h34,8'h12,8'h03,8'h15,8'h06,8'h24}}, // R3
    '{8'd3, 8'h02, {8'h59,8'h59,8'h09,8'h02,8'h10,8'h03,8'h21}, {8'h00,8'h00,8'h10,8'h02,8'h10,8'h03,8'h21}}, // R3
    '{8'd4, 8'h02, {8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99}, {8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00}}, // R4 R5
    '{8'd5, 8'h02, {8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h24}, {8'h00,8'h00,8'h00,8'h05,8'h29,8'h02,8'h24}}, // R5
    '{8'd5, 8'h02, {8'h59,8'h59,8'h23,8'h04,8'h28,8'h02,8'h23}, {8'h00,8'h00,8'h00,8'h05,8'h01,8'h03,8'h23}}, // R5
    '{8'd5, 8'h02, {8'h59,8'h59,8'h23,8'h01,8'h30,8'h04,8'h10}, {8'h00,8'h00,8'h00,8'h02,8'h01,8'h05,8'h10}}, // R5
    '{8'd6, 8'h06, {8'h3B,8'h3B,8'h16,8'h06,8'h1E,8'h06,8'h32}, {8'h00,8'h00,8'h17,8'h06,8'h1E,8'h06,8'h32}}, // R6
    '{8'd7, 8'h00, {8'h59,8'h59,8'h91,8'h03,8'h05,8'h07,8'h20}, {8'h00,8'h00,8'h12,8'h04,8'h06,8'h07,8'h20}}, // R7
    '{8'd7, 8'h00, {8'h59,8'h59,8'h11,8'h03,8'h05,8'h07,8'h20}, {8'h00,8'h00,8'h92,8'h03,8'h05,8'h07,8'h20}}, // R7
    '{8'd7, 8'h00, {8'h59,8'h59,8'h92,8'h03,8'h05,8'h07,8'h20}, {8'h00,8'h00,8'h81,8'h03,8'h05,8'h07,8'h20}}, // R7
    '{8'd7, 8'h04, {8'h3B,8'h3B,8'h8B,8'h02,8'h0F,8'h09,8'h07}, {8'h00,8'h00,8'h0C,8'h03,8'h10,8'h09,8'h07}}, // R7 R6
    '{8'd5, 8'h06, {8'h3B,8'h3B,8'h17,8'h05,8'h1E,8'h09,8'h01}, {8'h00,8'h00,8'h00,8'h06,8'h01,8'h0A,8'h01}}, // R5
    '{8'd5, 8'h02, {8'h59,8'h59,8'h23,8'h01,8'h29,8'h02,8'h00}, {8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h00}}  // R5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [3:0] reg_idx = 4'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       uip, irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  tod_clock dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .uip(uip), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk);
    reg_idx = idx; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] val);
    @(negedge clk);
    reg_idx = idx;
    #0.5 val = reg_rdata;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    reg_idx = 4'd12; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tick_wait();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    repeat (LEAD + HOLD + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       saw_uip;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 7; k++) begin
      logic [7:0] r1_exp [7] = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00};
      rd(FIDX[k], v);
      check("R1", $sformatf("reset idx %0d", FIDX[k]), v, r1_exp[k]);
    end
    rd(4'd10, v); check("R1", "reset status", v, 8'h00);
    rd(4'd11, v); check("R1", "reset ctrl", v, 8'h00);
    rd(4'd12, v); check("R1", "reset flags", v, 8'h00);
    check("R1", "reset uip/irq", {6'b0, uip, irq}, 8'h00);

    // Vector table: R3 R4 R5 R6 R7
    for (int n = 0; n < 13; n++) begin
      wr(4'd11, VECS[n].ctrl);
      for (int k = 0; k < 7; k++) wr(FIDX[k], VECS[n].din[55-8*k -: 8]);
      tick_wait();
      for (int k = 0; k < 7; k++) begin
        rd(FIDX[k], v);
        check($sformatf("R%0d", VECS[n].req),
              $sformatf("vec %0d idx %0d", n, FIDX[k]), v, VECS[n].dexp[55-8*k -: 8]);
      end
      clr_flags();
    end

    // R2 window timing
    wr(4'd11, 8'h02);
    wr(4'd0, 8'h10);
    @(negedge clk);
    reg_idx = 4'd0;
    check("R2", "uip before tick", {7'b0, uip}, 8'h00);
    tick_1hz = 1'b1;
    for (int i = 1; i <= LEAD + HOLD + 1; i++) begin
      @(negedge clk);
      tick_1hz = 1'b0;
      #0.5;
      if (i == 1)           check("R2", "uip rises", {7'b0, uip}, 8'h01);
      if (i == LEAD)        check("R2", "sec before advance", reg_rdata, 8'h10);
      if (i == LEAD + 1)    check("R2", "sec after advance", reg_rdata, 8'h11);
      if (i == LEAD + HOLD) check("R2", "uip last cycle", {7'b0, uip}, 8'h01);
      if (i == LEAD + HOLD + 1) check("R2", "uip falls", {7'b0, uip}, 8'h00);
    end
    clr_flags();

    // R10 status register
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    repeat (2) @(negedge clk);
    rd(4'd10, v); check("R10", "status in window", v, 8'h80);
    repeat (LEAD + HOLD) @(negedge clk);
    clr_flags();
    wr(4'd10, 8'hFF);
    rd(4'd10, v); check("R10", "status write ignored", v, 8'h00);
    rd(4'd1, v);  check("R10", "unused idx 1", v, 8'h00);
    rd(4'd13, v); check("R10", "unused idx 13", v, 8'h00);

    // R8 freeze
    wr(4'd11, 8'h82);
    wr(4'd0, 8'h30);
    saw_uip = 1'b0;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    for (int i = 0; i < LEAD + HOLD + 2; i++) begin
      @(negedge clk);
      if (uip) saw_uip = 1'b1;
    end
    check("R8", "uip while frozen", {7'b0, saw_uip}, 8'h00);
    rd(4'd0, v);  check("R8", "sec while frozen", v, 8'h30);
    rd(4'd12, v); check("R8", "flags while frozen", v, 8'h00);

    // R9 flag and interrupt
    wr(4'd11, 8'h12);
    tick_wait();
    check("R9", "irq enabled", {7'b0, irq}, 8'h01);
    rd(4'd12, v); check("R9", "flags with enable", v, 8'h90);
    clr_flags();
    rd(4'd12, v); check("R9", "flags after read", v, 8'h00);
    check("R9", "irq after read", {7'b0, irq}, 8'h00);
    wr(4'd11, 8'h02);
    tick_wait();
    rd(4'd12, v); check("R9", "flags without enable", v, 8'h10);
    check("R9", "irq masked", {7'b0, irq}, 8'h00);
    clr_flags();

    // R6 mode switch keeps the value
    wr(4'd11, 8'h06);
    wr(4'd0, 8'h2A);
    wr(4'd11, 8'h02);
    rd(4'd0, v); check("R6", "binary 42 read as BCD", v, 8'h42);
    // R7 24h value shown in 12h form
    wr(4'd11, 8'h06);
    wr(4'd4, 8'h0E);
    wr(4'd11, 8'h00);
    rd(4'd4, v); check("R7", "14h as 2 PM", v, 8'h82);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule